// File: doc/BRIEF.md
# Comma-Detecting Word Aligner

This block sits between clock-data recovery and an 8b/10b character decoder. It receives one recovered bit at a time, qualified by a bit-valid strobe, and keeps a 20-bit history of the stream. After every tenth valid bit it checks all ten possible character boundaries for the 7-bit comma prefix. Either running-disparity form of the prefix is accepted.

The first comma locks the boundary and raises the byte-sync flag. From then on the block emits one aligned 10-bit word per ten valid bits, each marked by a one-cycle word-valid strobe. A comma that lands on the locked boundary is passed on as an ordinary word and confirms sync. A comma found at another offset moves the boundary. On that switch tick no word is emitted and sync drops until a comma confirms the new boundary. Bits arrive first-to-last as word bit 0 through bit 9.

Top module: `comma_word_aligner`

## Requirements
- R1: Bits are assembled least-significant first. The first valid bit of a character becomes word_out[0] (position a) and the tenth becomes word_out[9] (position j).
- R2: A comma is a word whose bits [6:0] equal 7'b1111100 (a..f reading 0011111) or 7'b0000011 (a..f reading 1100000). Both forms lock the boundary.
- R3: Every tenth valid bit, all ten start offsets of the 20-bit history are searched. When several offsets hold a comma in the same search, the earliest-received one sets the boundary.
- R4: After reset, word_valid and byte_sync stay low until a comma is found. The tick that first sets the boundary emits no word.
- R5: The first comma raises byte_sync in the cycle after the search that finds it.
- R6: Once locked, each search emits the word on the locked boundary with a single-cycle word_valid pulse. A comma on that boundary is emitted like any other word and keeps byte_sync high.
- R7: A comma at a different offset moves the boundary. word_valid stays low on that tick and byte_sync falls; the next comma on the new boundary raises byte_sync again.
- R8: Cycles with bit_valid low neither shift the history nor advance the bit count, so idle gaps leave the aligned output unchanged.
- R9: Reset clears the lock, the stored offset and byte_sync. Data sent afterwards without a comma produces no words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_in | input | 1 | Recovered serial bit |
| bit_valid | input | 1 | Qualifies bit_in for this cycle |
| word_out | output | 10 | Aligned character, bit 0 received first |
| word_valid | output | 1 | One-cycle strobe marking word_out |
| byte_sync | output | 1 | Boundary locked and confirmed by the last comma |

## Verification
The bench builds the block with its default parameters: a 10-bit word, a 7-bit comma prefix and the two standard prefix patterns. This makes the real disparity-negative and disparity-positive comma characters the stimulus. The realignment case inserts three stray bits between commas. The priority case uses a 12-bit run that holds both prefix forms five bits apart inside one search window, so only earliest-offset selection yields the aligned data that follows. Back-to-back bits and streams with two idle cycles per bit both reach the same words.

// File: rtl/cwa_pkg.sv
package cwa_pkg;

  // character geometry
  localparam int unsigned CHAR_W  = 10;
  localparam int unsigned PREFIX_W = 7;

  // comma prefix, bit 0 = first received bit (position a)
  localparam logic [PREFIX_W-1:0] PREFIX_NEG = 7'b1111100;
  localparam logic [PREFIX_W-1:0] PREFIX_POS = 7'b0000011;

endpackage

// File: rtl/cwa_history.sv
module cwa_history #(
  parameter int unsigned CHAR_W = cwa_pkg::CHAR_W,
  localparam int unsigned WIN_W = 2 * CHAR_W,
  localparam int unsigned CNT_W = $clog2(CHAR_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_in,
  input  logic             bit_valid,
  output logic [WIN_W-1:0] hist_o,
  output logic             scan_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAR_W - 1);

  logic [WIN_W-1:0] hist_q, hist_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             scan_q, scan_d;

  // newest bit enters at the top, oldest leaves at bit 0
  always_comb begin
    hist_d = hist_q;
    cnt_d  = cnt_q;
    scan_d = 1'b0;
    if (bit_valid) begin
      hist_d = {bit_in, hist_q[WIN_W-1:1]};
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        scan_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      cnt_q  <= '0;
      scan_q <= 1'b0;
    end else begin
      hist_q <= hist_d;
      cnt_q  <= cnt_d;
      scan_q <= scan_d;
    end
  end

  assign hist_o = hist_q;
  assign scan_o = scan_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R6
  AST_SCAN_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    scan_q |-> $past(bit_valid)); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> $stable(hist_q)); // R8

endmodule

// File: rtl/cwa_scan.sv
module cwa_scan #(
  parameter int unsigned CHAR_W   = cwa_pkg::CHAR_W,
  parameter int unsigned PREFIX_W = cwa_pkg::PREFIX_W,
  parameter logic [PREFIX_W-1:0] PREFIX_NEG = cwa_pkg::PREFIX_NEG,
  parameter logic [PREFIX_W-1:0] PREFIX_POS = cwa_pkg::PREFIX_POS,
  localparam int unsigned WIN_W = 2 * CHAR_W,
  localparam int unsigned OFF_W = $clog2(CHAR_W)
) (
  input  logic [WIN_W-1:0] hist_i,
  output logic             hit_o,
  output logic [OFF_W-1:0] hit_off_o
);

  logic [CHAR_W-1:0] match;

  // one comparator pair per candidate start offset
  for (genvar k = 0; k < CHAR_W; k++) begin : g_off
    logic [PREFIX_W-1:0] seg;
    assign seg      = hist_i[k +: PREFIX_W];
    assign match[k] = (seg == PREFIX_NEG) || (seg == PREFIX_POS);
  end

  // earliest-received offset (lowest index) takes priority
  always_comb begin
    hit_o     = 1'b0;
    hit_off_o = '0;
    for (int k = CHAR_W - 1; k >= 0; k--) begin
      if (match[k]) begin
        hit_o     = 1'b1;
        hit_off_o = OFF_W'(k);
      end
    end
  end

endmodule

// File: rtl/cwa_align.sv
module cwa_align #(
  parameter int unsigned CHAR_W = cwa_pkg::CHAR_W,
  localparam int unsigned WIN_W = 2 * CHAR_W,
  localparam int unsigned OFF_W = $clog2(CHAR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIN_W-1:0]  hist_i,
  input  logic              scan_i,
  input  logic              hit_i,
  input  logic [OFF_W-1:0]  hit_off_i,
  output logic [CHAR_W-1:0] word_o,
  output logic              valid_o,
  output logic              sync_o
);

  logic [OFF_W-1:0]  off_q, off_d;
  logic              lock_q, lock_d;
  logic              sync_q, sync_d;
  logic [CHAR_W-1:0] word_q, word_d;
  logic              valid_q, valid_d;
  logic              moved;

  assign moved = hit_i && (!lock_q || (hit_off_i != off_q));

  always_comb begin
    off_d   = off_q;
    lock_d  = lock_q;
    sync_d  = sync_q;
    word_d  = word_q;
    valid_d = 1'b0;
    if (scan_i) begin
      if (moved) begin
        // boundary set or switched: this tick stays silent
        off_d  = hit_off_i;
        lock_d = 1'b1;
        sync_d = !lock_q;
      end else if (lock_q) begin
        word_d  = hist_i[off_q +: CHAR_W];
        valid_d = 1'b1;
        if (hit_i) begin
          sync_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q   <= '0;
      lock_q  <= 1'b0;
      sync_q  <= 1'b0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      off_q   <= off_d;
      lock_q  <= lock_d;
      sync_q  <= sync_d;
      word_q  <= word_d;
      valid_q <= valid_d;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
  assign sync_o  = sync_q;

  AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> lock_q); // R4
  AST_LOCK_TICK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> !valid_q); // R4
  AST_FIRST_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_i && hit_i && !lock_q) |=> sync_q); // R5
  AST_SYNC_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |-> lock_q); // R5
  AST_VALID_FROM_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(scan_i)); // R6
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q); // R6
  AST_SWITCH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(off_q) |-> !valid_q); // R7
  AST_SWITCH_DROPS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_i && hit_i && lock_q && (hit_off_i != off_q)) |=> !sync_q); // R7

endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner #(
  parameter int unsigned CHAR_W   = cwa_pkg::CHAR_W,
  parameter int unsigned PREFIX_W = cwa_pkg::PREFIX_W,
  parameter logic [PREFIX_W-1:0] PREFIX_NEG = cwa_pkg::PREFIX_NEG,
  parameter logic [PREFIX_W-1:0] PREFIX_POS = cwa_pkg::PREFIX_POS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  input  logic              bit_valid,
  output logic [CHAR_W-1:0] word_out,
  output logic              word_valid,
  output logic              byte_sync
);

  localparam int unsigned WIN_W = 2 * CHAR_W;
  localparam int unsigned OFF_W = $clog2(CHAR_W);

  // asynchronous assertion, synchronous release
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [WIN_W-1:0] hist;
  logic             scan;
  logic             hit;
  logic [OFF_W-1:0] hit_off;

  cwa_history #(.CHAR_W(CHAR_W)) u_hist (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .bit_in    (bit_in),
    .bit_valid (bit_valid),
    .hist_o    (hist),
    .scan_o    (scan)
  );

  cwa_scan #(
    .CHAR_W     (CHAR_W),
    .PREFIX_W   (PREFIX_W),
    .PREFIX_NEG (PREFIX_NEG),
    .PREFIX_POS (PREFIX_POS)
  ) u_scan (
    .hist_i    (hist),
    .hit_o     (hit),
    .hit_off_o (hit_off)
  );

  cwa_align #(.CHAR_W(CHAR_W)) u_align (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .hist_i    (hist),
    .scan_i    (scan),
    .hit_i     (hit),
    .hit_off_i (hit_off),
    .word_o    (word_out),
    .valid_o   (word_valid),
    .sync_o    (byte_sync)
  );

endmodule

// File: tb/comma_word_aligner_test.sv
module comma_word_aligner_test;

  localparam int CLK_PERIOD = 10;

  localparam logic [9:0] K_NEG = 10'b0101111100;
  localparam logic [9:0] K_POS = 10'b1010000011;
  localparam logic [9:0] D1 = 10'b0110100110;
  localparam logic [9:0] D2 = 10'b1001011001;
  localparam logic [9:0] D3 = 10'b0101101100;
  localparam logic [9:0] D4 = 10'b1101001011;
  localparam logic [9:0] D5 = 10'b0011010010;
  localparam logic [9:0] D6 = 10'b1010011010;
  localparam logic [9:0] D7 = 10'b0100101101;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_in = 1'b0;
  logic       bit_valid = 1'b0;
  logic [9:0] word_out;
  logic       word_valid;
  logic       byte_sync;

  int checks = 0;
  int errors = 0;

  logic [9:0] cap [0:255];
  int  ncap = 0;
  int  rises = 0, rise_vld = 0, falls = 0, fall_vld = 0, doubles = 0;
  bit  prev_vld = 1'b0, prev_sync = 1'b0;
  bit  alt = 1'b0;
  int  gap = 0;

  comma_word_aligner uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_in     (bit_in),
    .bit_valid  (bit_valid),
    .word_out   (word_out),
    .word_valid (word_valid),
    .byte_sync  (byte_sync)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (word_valid) begin
      if (ncap < 256) cap[ncap] = word_out;
      ncap++;
      if (prev_vld) doubles++;
    end
    if (byte_sync && !prev_sync) begin
      rises++;
      if (word_valid) rise_vld++;
    end
    if (!byte_sync && prev_sync && rst_n) begin
      falls++;
      if (word_valid) fall_vld++;
    end
    prev_vld  = word_valid;
    prev_sync = byte_sync;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    ncap = 0; rises = 0; rise_vld = 0; falls = 0; fall_vld = 0; doubles = 0;
  endtask

  task automatic do_reset();
    bit_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    clear_log();
  endtask

  task automatic send_bit(input logic b);
    bit_in = b;
    bit_valid = 1'b1;
    @(negedge clk);
    if (gap > 0) begin
      bit_valid = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic send_word(input logic [9:0] w);
    for (int i = 0; i < 10; i++) send_bit(w[i]);
  endtask

  task automatic send_filler(input int n);
    for (int i = 0; i < n; i++) begin
      send_bit(alt);
      alt = ~alt;
    end
  endtask

  task automatic finish_stream();
    send_filler(20);
    bit_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R4", "word_valid after reset", word_valid, 0);
    chk("R4", "byte_sync after reset", byte_sync, 0);
  endtask

  task automatic t_no_comma();
    do_reset();
    send_filler(15);
    send_word(D1); send_word(D2); send_word(D3);
    finish_stream();
    chk("R4", "words without comma", ncap, 0);
    chk("R4", "sync without comma", byte_sync, 0);
  endtask

  task automatic t_lock_neg();
    do_reset();
    send_filler(23);
    send_word(K_NEG);
    send_word(D1); send_word(D2); send_word(D3); send_word(D4);
    send_word(K_NEG);
    finish_stream();
    chk("R5", "sync rises once", rises, 1);
    chk("R4", "lock tick emits no word", rise_vld, 0);
    chk("R1", "first word bit order", cap[0], D1);
    chk("R6", "word 2", cap[1], D2);
    chk("R6", "word 3", cap[2], D3);
    chk("R6", "word 4", cap[3], D4);
    chk("R2", "comma on boundary emitted", cap[4], K_NEG);
    chk("R6", "sync held", byte_sync, 1);
    chk("R6", "single-cycle strobes", doubles, 0);
  endtask

  task automatic t_realign();
    int c0, idx;
    c0 = ncap;
    send_filler(3);
    send_word(K_POS);
    send_word(D5); send_word(D6); send_word(D7);
    send_word(K_POS);
    finish_stream();
    chk("R7", "sync falls at switch", falls, 1);
    chk("R7", "switch tick silent", fall_vld, 0);
    chk("R7", "sync regained", rises, 2);
    idx = -1;
    for (int i = c0; i < ncap && i < 256; i++) if (idx < 0 && cap[i] == D5) idx = i;
    chk("R7", "new-boundary word found", (idx >= 0) ? 1 : 0, 1);
    if (idx >= 0 && idx + 3 < 256) begin
      chk("R7", "word after D5", cap[idx+1], D6);
      chk("R7", "word after D6", cap[idx+2], D7);
      chk("R2", "positive comma emitted", cap[idx+3], K_POS);
    end
    chk("R7", "sync at end", byte_sync, 1);
  endtask

  task automatic t_priority();
    do_reset();
    send_filler(23);
    send_bit(0); send_bit(0); send_bit(1); send_bit(1); send_bit(1); send_bit(1);
    send_bit(1); send_bit(0); send_bit(0); send_bit(0); send_bit(0); send_bit(0);
    alt = 1'b1;
    send_filler(8);
    send_word(D1); send_word(D2);
    finish_stream();
    chk("R3", "one lock only", rises, 1);
    chk("R3", "earliest offset word 1", cap[1], D1);
    chk("R3", "earliest offset word 2", cap[2], D2);
  endtask

  task automatic t_gaps();
    do_reset();
    gap = 2;
    send_filler(17);
    send_word(K_NEG);
    send_word(D2); send_word(D3); send_word(D1);
    finish_stream();
    gap = 0;
    chk("R8", "gapped word 1", cap[0], D2);
    chk("R8", "gapped word 2", cap[1], D3);
    chk("R8", "gapped word 3", cap[2], D1);
    chk("R8", "gapped sync", byte_sync, 1);
  endtask

  task automatic t_reset_mid();
    chk("R9", "locked before reset", byte_sync, 1);
    do_reset();
    chk("R9", "sync cleared", byte_sync, 0);
    chk("R9", "valid cleared", word_valid, 0);
    send_word(D4); send_word(D5); send_word(D6);
    finish_stream();
    chk("R9", "no words after reset", ncap, 0);
  endtask

  initial begin
    t_reset_state();
    t_no_comma();
    t_lock_neg();
    t_realign();
    t_priority();
    t_gaps();
    t_reset_mid();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule